// File: doc/BRIEF.md
# Microcode Sequencer for Long Instructions

This block expands a complex instruction into a long run of micro-ops. The front end uses it only for instructions that translate into more than four micro-ops. For such an instruction it presents a start request together with an entry address into a built-in micro-op table. A micro-program counter then walks the table one word per accepted cycle. Each word goes to register rename as one micro-op.

The next value of the counter comes from a two-way choice: the external entry address when a sequence starts, otherwise the counter plus one. This lets one table hold many sequences back to back. A word whose end bit is set closes the sequence, and the block then drops busy. Backpressure from rename freezes the counter and the output word.

The table holds three sequences. The first saves all eight registers and is eighteen micro-ops long. The second restores them in nine. The third is a five-step sequence. Every other address holds a single terminating no-op.

Top module: `ucode_seq`

## Requirements
- R1: After reset, busy_o and uop_valid_o are low.
- R2: start_i while idle loads entry_i into the micro-PC. From the next cycle busy_o and uop_valid_o are high and uop_o/uop_last_o show the table word at entry_i.
- R3: A micro-op is {op[15:12], reg[11:8], imm[7:0]}. Addresses 0..17 hold the save-all sequence:
  - address 0 is {1,4,0}.
  - odd address a is {4,(a-1)/2,4*((a+1)/2)}.
  - even address a in 2..16 is {3,(a-2)/2,0}.
  - address 17 is {2,4,0x20} with the end bit set.
- R4: Addresses 24..31 hold {5,7-(a-24),4*(a-24)}. Address 32 is {2,4,0xE0} with the end bit set. Addresses 40..44 hold {6,a-40,a-40}, and only 44 has the end bit set. Every other address holds 0 with the end bit set.
- R5: Each cycle with uop_valid_o and uop_ready_i high on a word whose end bit is clear advances the micro-PC by one.
- R6: While uop_valid_o is high and uop_ready_i is low, uop_o, uop_last_o and the micro-PC hold.
- R7: Once the end-bit word is accepted, busy_o and uop_valid_o are low in the next cycle.
- R8: start_i while busy_o is high is ignored. The running sequence continues at the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a sequence |
| entry_i | input | ADDR_W | Entry address of the sequence |
| busy_o | output | 1 | A sequence is running |
| uop_valid_o | output | 1 | uop_o holds a micro-op for rename |
| uop_o | output | 16 | Current micro-op |
| uop_last_o | output | 1 | Current micro-op ends the sequence |
| uop_ready_i | input | 1 | Rename accepts the micro-op this cycle |

## Verification
The assertions assume that start_i and uop_ready_i are driven to known values in every cycle after reset. They also assume that entry_i is stable in the cycle start_i is sampled. The stimulus holds to this by driving every input only at the falling edge and holding each value for a full cycle. Entry points both inside and outside the defined sequences are exercised, together with ready patterns that stall, including stalls on the first and last words.

// File: rtl/ucode_seq.sv
module ucode_seq #(
  parameter int ADDR_W    = 6,
  parameter int SAVE_BASE = 0,
  parameter int REST_BASE = 24,
  parameter int STEP_BASE = 40,
  parameter int STEP_LEN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] entry_i,
  output logic              busy_o,
  output logic              uop_valid_o,
  output logic [15:0]       uop_o,
  output logic              uop_last_o,
  input  logic              uop_ready_i
);
  localparam int SAVE_LEN = 18;
  localparam int REST_LEN = 9;

  logic [ADDR_W-1:0] upc;
  logic              busy;
  logic [16:0]       word;

  function automatic logic [16:0] table_word(input logic [ADDR_W-1:0] a);
    int k;
    int j;
    logic [16:0] w;
    w = {1'b1, 16'h0000};
    k = int'(a) - SAVE_BASE;
    if (k >= 0 && k < SAVE_LEN) begin
      j = (k - 1) / 2;
      if (k == 0)                w = {1'b0, 4'h1, 4'h4, 8'h00};
      else if (k == SAVE_LEN-1)  w = {1'b1, 4'h2, 4'h4, 8'h20};
      else if (k % 2 == 1)       w = {1'b0, 4'h4, 4'(j), 8'(4 * (j + 1))};
      else                       w = {1'b0, 4'h3, 4'(j), 8'h00};
    end
    k = int'(a) - REST_BASE;
    if (k >= 0 && k < REST_LEN) begin
      if (k == REST_LEN-1) w = {1'b1, 4'h2, 4'h4, 8'hE0};
      else                 w = {1'b0, 4'h5, 4'(7 - k), 8'(4 * k)};
    end
    k = int'(a) - STEP_BASE;
    if (k >= 0 && k < STEP_LEN)
      w = {k == STEP_LEN-1, 4'h6, 4'(k), 8'(k)};
    return w;
  endfunction

  wire accept  = start_i && !busy;
  wire advance = busy && uop_ready_i;

  assign word        = table_word(upc);
  assign busy_o      = busy;
  assign uop_valid_o = busy;
  assign uop_o       = word[15:0];
  assign uop_last_o  = word[16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      upc  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      upc  <= entry_i;
    end else if (advance) begin
      if (word[16]) busy <= 1'b0;
      else          upc  <= upc + 1'b1;
    end
  end

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && upc == $past(entry_i)));
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid_o && uop_ready_i && !uop_last_o) |=> (busy_o && upc == $past(upc) + 1'b1));
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid_o && !uop_ready_i) |=> (uop_valid_o && $stable(uop_o) && $stable(upc) && $stable(uop_last_o)));
  a_r7_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid_o && uop_ready_i && uop_last_o) |=> (!busy_o && !uop_valid_o));
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !uop_ready_i) |=> $stable(upc));
endmodule

// File: tb/ucode_seq_test.sv
module ucode_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [5:0] entry_i = '0;
  logic uop_ready_i = 1'b0;
  logic busy_o, uop_valid_o, uop_last_o;
  logic [15:0] uop_o;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  ucode_seq uut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .entry_i(entry_i),
                 .busy_o(busy_o), .uop_valid_o(uop_valid_o), .uop_o(uop_o),
                 .uop_last_o(uop_last_o), .uop_ready_i(uop_ready_i));

  always #10 clk = ~clk;

  function automatic logic [16:0] expect_word(input int a);
    if (a == 0)                 return {1'b0, 4'h1, 4'h4, 8'h00};
    if (a == 17)                return {1'b1, 4'h2, 4'h4, 8'h20};
    if (a < 17 && a % 2 == 1)   return {1'b0, 4'h4, 4'((a - 1) / 2), 8'(4 * ((a + 1) / 2))};
    if (a < 17)                 return {1'b0, 4'h3, 4'((a - 2) / 2), 8'h00};
    if (a >= 24 && a <= 31)     return {1'b0, 4'h5, 4'(31 - a), 8'(4 * (a - 24))};
    if (a == 32)                return {1'b1, 4'h2, 4'h4, 8'hE0};
    if (a >= 40 && a <= 44)     return {a == 44, 4'h6, 4'(a - 40), 8'(a - 40)};
    return {1'b1, 16'h0000};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic kick(input int entry);
    start_i = 1'b1;
    entry_i = 6'(entry);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain(input int addr, input logic [7:0] mask, input int exp_len, input string req);
    int a = addr;
    int done = 0;
    for (int i = 0; i < 200 && done == 0; i++) begin
      uop_ready_i = mask[i % 8];
      check(req, {15'd0, uop_valid_o, uop_last_o, uop_o}, {15'd0, 1'b1, expect_word(a)});
      if (uop_ready_i) begin
        if (uop_last_o) done = 1;
        a++;
      end
      @(posedge clk);
      @(negedge clk);
    end
    uop_ready_i = 1'b0;
    check({req, " R7 length"}, 32'(a - addr), 32'(exp_len));
    check("R7 idle after end", {30'd0, busy_o, uop_valid_o}, 32'd0);
  endtask

  localparam int NV = 5;
  localparam logic [21:0] VEC [NV] = '{
    {6'd0,  8'hFF, 8'd18},
    {6'd24, 8'b1011_0110, 8'd9},
    {6'd40, 8'b0101_0101, 8'd5},
    {6'd17, 8'b1111_1110, 8'd1},
    {6'd10, 8'b1100_1101, 8'd8}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset idle", {30'd0, busy_o, uop_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {30'd0, busy_o, uop_valid_o}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      kick(int'(VEC[v][21:16]));
      check("R2 busy after start", {31'd0, busy_o}, 32'd1);
      drain(int'(VEC[v][21:16]), VEC[v][15:8], int'(VEC[v][7:0]), "R3 R4 R5 sequence");
    end

    kick(0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R6 stall hold", {16'd0, uop_o}, {16'd0, expect_word(0)});
    end
    uop_ready_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b1;
    entry_i = 6'd40;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check("R8 start ignored while busy", {15'd0, uop_last_o, uop_o}, {15'd0, expect_word(3)});
    drain(3, 8'hFF, 15, "R8 continue");

    kick(60);
    drain(60, 8'hFF, 1, "R4 unmapped no-op");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule